// File: doc/BRIEF.md
# Dual Phase Detector with Lock Output Selector

This block holds two phase-frequency detectors that work side by side, one for a high-band synthesizer channel and one for a low-band channel. Each detector watches a reference-divider pulse and a feedback-divider pulse. It raises a pump-up or pump-down request according to which rising edge comes first. When the lagging edge arrives, both requests are held together for a fixed clear interval and then dropped. A per-channel polarity bit can swap the two requests for a tuning element whose frequency falls as its control voltage rises. Each channel also drives a charge-pump drive enable and a gain-select output for the analog pump model.

Every channel produces a quiet indication. It is high while that channel's pump is idle and low while it is pumping, so a locked loop shows a narrow low pulse at each comparison. A third indication is high only when both channels are quiet. A 4-bit selector routes one of these indications, one of the four divider inputs, or a constant level to a single shared test pin that has its own output enable. Powerdown releases the pin to high impedance whatever the selector code is.

Each detector is a four-state machine. ST_IDLE goes to ST_LEAD_REF on a reference edge alone, to ST_LEAD_FB on a feedback edge alone, and to ST_CLEAR when both edges come in the same cycle. ST_LEAD_REF goes to ST_CLEAR on a feedback edge. ST_LEAD_FB goes to ST_CLEAR on a reference edge. ST_CLEAR stays for RST_CYCLES cycles and then returns to ST_IDLE. Any other case holds the current state.

Top module: `dual_pfd_lockmux`

## Requirements
- R1: While reset is asserted and right after it, every up, down and drive-enable output is low and all three quiet indications are high.
- R2: A reference rising edge alone raises the up output (polarity 1) at the next clock edge. The up output stays high until a feedback rising edge arrives. Up and down are then both high for RST_CYCLES (2) cycles, after which both are low.
- R3: A feedback rising edge alone raises the down output (polarity 1) at the next clock edge. A later reference rising edge makes up and down both high for 2 cycles, after which both are low.
- R4: Reference and feedback rising edges in the same cycle make up and down both high for exactly 2 cycles. This is the minimum pulse width.
- R5: With a channel's polarity bit at 0, that channel's up and down outputs are swapped. A lone reference edge then raises down, not up.
- R6: A channel's drive-enable output is high exactly when its up or down output is high. It is low (pump in high impedance) otherwise.
- R7: A channel's quiet output is the inverse of its drive enable.
- R8: The combined quiet output is high only when both channel quiet outputs are high.
- R9: With powerdown low, selector codes behave as follows. Code 0 gives output enable 0. Code 1 drives 0. Code 2 drives 1. Code 3 gives high-band quiet, 4 low-band quiet, and 5 combined quiet. Codes 6 and 7 give the high-band reference and feedback inputs. Codes 8 and 9 give the low-band reference and feedback inputs. Every code from 1 to 9 sets output enable to 1.
- R10: Selector codes 10 to 15 drive the pin low with output enable 1.
- R11: With powerdown high, the test output is 0 and its enable is 0 for every selector code.
- R12: Each channel's gain-select output follows its gain control input.
- R13: Rising edges that arrive while a channel is in its clear interval are ignored. No new request follows the clear interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_hi | input | 1 | High-band reference divider pulse |
| fb_hi | input | 1 | High-band feedback divider pulse |
| pol_hi | input | 1 | High-band polarity (1 normal, 0 swapped) |
| gain_hi | input | 1 | High-band pump current select |
| ref_lo | input | 1 | Low-band reference divider pulse |
| fb_lo | input | 1 | Low-band feedback divider pulse |
| pol_lo | input | 1 | Low-band polarity (1 normal, 0 swapped) |
| gain_lo | input | 1 | Low-band pump current select |
| out_sel | input | 4 | Test pin source code |
| pwr_down | input | 1 | Powerdown; releases the test pin |
| up_hi | output | 1 | High-band pump-up request |
| dn_hi | output | 1 | High-band pump-down request |
| cp_en_hi | output | 1 | High-band pump drive enable |
| cp_gain_hi | output | 1 | High-band gain select |
| up_lo | output | 1 | Low-band pump-up request |
| dn_lo | output | 1 | Low-band pump-down request |
| cp_en_lo | output | 1 | Low-band pump drive enable |
| cp_gain_lo | output | 1 | Low-band gain select |
| pump_quiet_hi | output | 1 | High while the high-band pump is idle |
| pump_quiet_lo | output | 1 | High while the low-band pump is idle |
| pump_quiet_both | output | 1 | High while both pumps are idle |
| test_out | output | 1 | Test pin data |
| test_oe | output | 1 | Test pin output enable |

## Verification
The hardest case to reach from the ports is a fresh rising edge that lands inside the clear interval. Both requests are already high at that point, so only the cycles after the clear interval show whether the edge was ignored. The bench drives both inputs high together to enter the clear interval. It drops the reference for one cycle and raises it again so that the new edge meets the last clear cycle. It then checks that no request appears afterwards. A second hard case is a divider monitor code read back while a channel is mid-pump. The bench holds a lone reference edge in its leading state and sweeps the selector before it sends the feedback edge.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    localparam int NUM_CH = 2;
    localparam int CH_HI  = 0;
    localparam int CH_LO  = 1;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_LEAD_REF = 2'd1,
        ST_LEAD_FB  = 2'd2,
        ST_CLEAR    = 2'd3
    } pfd_state_e;

    typedef enum logic [3:0] {
        SEL_HIZ     = 4'd0,
        SEL_LOW     = 4'd1,
        SEL_HIGH    = 4'd2,
        SEL_Q_HI    = 4'd3,
        SEL_Q_LO    = 4'd4,
        SEL_Q_BOTH  = 4'd5,
        SEL_REF_HI  = 4'd6,
        SEL_FB_HI   = 4'd7,
        SEL_REF_LO  = 4'd8,
        SEL_FB_LO   = 4'd9
    } out_sel_e;

endpackage

// File: rtl/pfd_channel.sv
module pfd_channel
    import pfd_pkg::*;
#(
    parameter int RST_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic fb_in,
    input  logic pol,
    input  logic gain_in,
    output logic up,
    output logic dn,
    output logic cp_en,
    output logic quiet,
    output logic cp_gain
);

    localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(RST_CYCLES - 1);

    pfd_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          ref_q, fb_q;
    logic          ref_rise, fb_rise;
    logic          up_raw, dn_raw;

    assign ref_rise = ref_in & ~ref_q;
    assign fb_rise  = fb_in & ~fb_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ref_q   <= 1'b0;
            fb_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ref_q   <= ref_in;
            fb_q    <= fb_in;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_rise && fb_rise) begin
                    state_d = ST_CLEAR;
                    cnt_d   = '0;
                end else if (ref_rise) begin
                    state_d = ST_LEAD_REF;
                end else if (fb_rise) begin
                    state_d = ST_LEAD_FB;
                end
            end
            ST_LEAD_REF: begin
                if (fb_rise) begin
                    state_d = ST_CLEAR;
                    cnt_d   = '0;
                end
            end
            ST_LEAD_FB: begin
                if (ref_rise) begin
                    state_d = ST_CLEAR;
                    cnt_d   = '0;
                end
            end
            ST_CLEAR: begin
                if (cnt_q == CNT_LAST) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        up_raw = 1'b0;
        dn_raw = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_LEAD_REF: up_raw = 1'b1;
            ST_LEAD_FB:  dn_raw = 1'b1;
            ST_CLEAR: begin
                up_raw = 1'b1;
                dn_raw = 1'b1;
            end
            default: ;
        endcase
    end

    assign up      = pol ? up_raw : dn_raw;
    assign dn      = pol ? dn_raw : up_raw;
    assign cp_en   = up_raw | dn_raw;
    assign quiet   = ~cp_en;
    assign cp_gain = gain_in;

endmodule

// File: rtl/lock_out_mux.sv
module lock_out_mux
    import pfd_pkg::*;
(
    input  logic       [3:0] sel,
    input  logic             pwr_down,
    input  logic [NUM_CH-1:0] quiet_ch,
    input  logic             quiet_all,
    input  logic [NUM_CH-1:0] ref_lvl,
    input  logic [NUM_CH-1:0] fb_lvl,
    output logic             pin_out,
    output logic             pin_oe
);

    always_comb begin
        pin_out = 1'b0;
        pin_oe  = 1'b1;
        if (pwr_down) begin
            pin_oe = 1'b0;
        end else begin
            case (out_sel_e'(sel))
                SEL_HIZ:    pin_oe  = 1'b0;
                SEL_LOW:    pin_out = 1'b0;
                SEL_HIGH:   pin_out = 1'b1;
                SEL_Q_HI:   pin_out = quiet_ch[CH_HI];
                SEL_Q_LO:   pin_out = quiet_ch[CH_LO];
                SEL_Q_BOTH: pin_out = quiet_all;
                SEL_REF_HI: pin_out = ref_lvl[CH_HI];
                SEL_FB_HI:  pin_out = fb_lvl[CH_HI];
                SEL_REF_LO: pin_out = ref_lvl[CH_LO];
                SEL_FB_LO:  pin_out = fb_lvl[CH_LO];
                default:    pin_out = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/dual_pfd_lockmux.sv
module dual_pfd_lockmux
    import pfd_pkg::*;
#(
    parameter int RST_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_hi,
    input  logic       fb_hi,
    input  logic       pol_hi,
    input  logic       gain_hi,
    input  logic       ref_lo,
    input  logic       fb_lo,
    input  logic       pol_lo,
    input  logic       gain_lo,
    input  logic [3:0] out_sel,
    input  logic       pwr_down,
    output logic       up_hi,
    output logic       dn_hi,
    output logic       cp_en_hi,
    output logic       cp_gain_hi,
    output logic       up_lo,
    output logic       dn_lo,
    output logic       cp_en_lo,
    output logic       cp_gain_lo,
    output logic       pump_quiet_hi,
    output logic       pump_quiet_lo,
    output logic       pump_quiet_both,
    output logic       test_out,
    output logic       test_oe
);

    logic [NUM_CH-1:0] ref_v, fb_v, pol_v, gain_v;
    logic [NUM_CH-1:0] up_v, dn_v, en_v, quiet_v, cpg_v;

    assign ref_v  = {ref_lo, ref_hi};
    assign fb_v   = {fb_lo, fb_hi};
    assign pol_v  = {pol_lo, pol_hi};
    assign gain_v = {gain_lo, gain_hi};

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            pfd_channel #(
                .RST_CYCLES(RST_CYCLES)
            ) u_ch (
                .clk     (clk),
                .rst_n   (rst_n),
                .ref_in  (ref_v[c]),
                .fb_in   (fb_v[c]),
                .pol     (pol_v[c]),
                .gain_in (gain_v[c]),
                .up      (up_v[c]),
                .dn      (dn_v[c]),
                .cp_en   (en_v[c]),
                .quiet   (quiet_v[c]),
                .cp_gain (cpg_v[c])
            );
        end
    endgenerate

    assign up_hi           = up_v[CH_HI];
    assign dn_hi           = dn_v[CH_HI];
    assign cp_en_hi        = en_v[CH_HI];
    assign cp_gain_hi      = cpg_v[CH_HI];
    assign up_lo           = up_v[CH_LO];
    assign dn_lo           = dn_v[CH_LO];
    assign cp_en_lo        = en_v[CH_LO];
    assign cp_gain_lo      = cpg_v[CH_LO];
    assign pump_quiet_hi   = quiet_v[CH_HI];
    assign pump_quiet_lo   = quiet_v[CH_LO];
    assign pump_quiet_both = &quiet_v;

    lock_out_mux u_mux (
        .sel       (out_sel),
        .pwr_down  (pwr_down),
        .quiet_ch  (quiet_v),
        .quiet_all (pump_quiet_both),
        .ref_lvl   (ref_v),
        .fb_lvl    (fb_v),
        .pin_out   (test_out),
        .pin_oe    (test_oe)
    );

endmodule

// File: rtl/pfd_checker.sv
module pfd_checker #(
    parameter int RST_CYCLES = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       up_hi,
    input logic       dn_hi,
    input logic       cp_en_hi,
    input logic       up_lo,
    input logic       dn_lo,
    input logic       cp_en_lo,
    input logic       pump_quiet_hi,
    input logic       pump_quiet_lo,
    input logic       pump_quiet_both,
    input logic [3:0] out_sel,
    input logic       pwr_down,
    input logic       test_out,
    input logic       test_oe
);

    localparam int RW = $clog2(RST_CYCLES + 2);
    localparam logic [RW-1:0] RUN_MAX = RW'(RST_CYCLES);

    logic [RW-1:0] run_hi, run_lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_hi <= '0;
            run_lo <= '0;
        end else begin
            run_hi <= (up_hi && dn_hi) ? ((run_hi < RUN_MAX) ? run_hi + RW'(1) : run_hi) : '0;
            run_lo <= (up_lo && dn_lo) ? ((run_lo < RUN_MAX) ? run_lo + RW'(1) : run_lo) : '0;
        end
    end

    // R6
    drive_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cp_en_hi == (up_hi || dn_hi));
    // R6
    drive_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cp_en_lo == (up_lo || dn_lo));
    // R7
    quiet_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pump_quiet_hi == !cp_en_hi);
    // R8
    quiet_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pump_quiet_both == (!cp_en_hi && !cp_en_lo));
    // R4
    both_cap_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_hi && dn_hi) |-> (run_hi < RUN_MAX));
    // R4
    both_len_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(up_hi && dn_hi) && run_hi != '0) |-> (run_hi == RUN_MAX));
    // R4
    both_len_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(up_lo && dn_lo) && run_lo != '0) |-> (run_lo == RUN_MAX));
    // R11
    pd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> (!test_oe && !test_out));
    // R10
    spare_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_down && out_sel >= 4'd10) |-> (test_oe && !test_out));

endmodule

bind dual_pfd_lockmux pfd_checker #(.RST_CYCLES(RST_CYCLES)) u_pfd_chk (.*);

// File: tb/test_dual_pfd_lockmux.sv
module test_dual_pfd_lockmux;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;
    // fields: sel[6:3], pwr_down[2], expected out[1], expected oe[0]
    localparam logic [6:0] VEC [NVEC] = '{
        {4'd0,  1'b0, 1'b0, 1'b0},
        {4'd1,  1'b0, 1'b0, 1'b1},
        {4'd2,  1'b0, 1'b1, 1'b1},
        {4'd3,  1'b0, 1'b1, 1'b1},
        {4'd4,  1'b0, 1'b1, 1'b1},
        {4'd5,  1'b0, 1'b1, 1'b1},
        {4'd6,  1'b0, 1'b0, 1'b1},
        {4'd7,  1'b0, 1'b0, 1'b1},
        {4'd8,  1'b0, 1'b1, 1'b1},
        {4'd9,  1'b0, 1'b1, 1'b1},
        {4'd10, 1'b0, 1'b0, 1'b1},
        {4'd15, 1'b0, 1'b0, 1'b1},
        {4'd2,  1'b1, 1'b0, 1'b0},
        {4'd5,  1'b1, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_hi = 0, fb_hi = 0, pol_hi = 1, gain_hi = 0;
    logic ref_lo = 0, fb_lo = 0, pol_lo = 1, gain_lo = 0;
    logic [3:0] out_sel = 4'd0;
    logic pwr_down = 0;
    logic up_hi, dn_hi, cp_en_hi, cp_gain_hi;
    logic up_lo, dn_lo, cp_en_lo, cp_gain_lo;
    logic pump_quiet_hi, pump_quiet_lo, pump_quiet_both;
    logic test_out, test_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dual_pfd_lockmux i_dual_pfd_lockmux (.*);

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drive_edge();
        @(negedge clk);
    endtask

    // {up, dn} of the high-band channel
    function automatic logic [7:0] ud_hi();
        return {6'd0, up_hi, dn_hi};
    endfunction

    function automatic logic [7:0] ud_lo();
        return {6'd0, up_lo, dn_lo};
    endfunction

    initial begin
        repeat (3) tick();
        // R1 reset state
        chk("R1", "up/dn hi in reset", ud_hi(), 8'd0);
        chk("R1", "up/dn lo in reset", ud_lo(), 8'd0);
        chk("R1", "quiet both in reset", {7'd0, pump_quiet_both}, 8'd1);
        drive_edge();
        rst_n = 1'b1;
        tick();
        chk("R1", "drive hi after reset", {7'd0, cp_en_hi}, 8'd0);

        // table precondition: low-band divider levels high, channels idle
        drive_edge();
        ref_lo = 1; fb_lo = 1;
        repeat (4) tick();
        for (int i = 0; i < NVEC; i++) begin
            drive_edge();
            out_sel  = VEC[i][6:3];
            pwr_down = VEC[i][2];
            tick();
            if (VEC[i][2])
                chk("R11", $sformatf("pin vec %0d", i), {6'd0, test_out, test_oe}, {6'd0, VEC[i][1:0]});
            else if (VEC[i][6:3] >= 4'd10)
                chk("R10", $sformatf("pin vec %0d", i), {6'd0, test_out, test_oe}, {6'd0, VEC[i][1:0]});
            else
                chk("R9", $sformatf("pin vec %0d", i), {6'd0, test_out, test_oe}, {6'd0, VEC[i][1:0]});
        end
        drive_edge();
        pwr_down = 0; ref_lo = 0; fb_lo = 0;
        tick();

        // R2 reference leads on the high band
        drive_edge();
        ref_hi = 1;
        tick();
        chk("R2", "up after ref edge", ud_hi(), 8'b10);
        chk("R6", "drive while up", {7'd0, cp_en_hi}, 8'd1);
        chk("R7", "quiet hi while up", {7'd0, pump_quiet_hi}, 8'd0);
        chk("R7", "quiet lo untouched", {7'd0, pump_quiet_lo}, 8'd1);
        chk("R8", "combined low while hi pumps", {7'd0, pump_quiet_both}, 8'd0);
        drive_edge();
        out_sel = 4'd3;
        #1 chk("R9", "pin code 3 mid pump", {7'd0, test_out}, 8'd0);
        drive_edge();
        out_sel = 4'd6;
        #1 chk("R9", "pin code 6 ref level", {7'd0, test_out}, 8'd1);
        drive_edge();
        out_sel = 4'd7;
        #1 chk("R9", "pin code 7 fb level", {7'd0, test_out}, 8'd0);
        tick();
        chk("R2", "up held without fb", ud_hi(), 8'b10);
        drive_edge();
        fb_hi = 1;
        tick();
        chk("R2", "both after fb edge c1", ud_hi(), 8'b11);
        tick();
        chk("R2", "both after fb edge c2", ud_hi(), 8'b11);
        tick();
        chk("R2", "clear after interval", ud_hi(), 8'b00);
        chk("R6", "drive off when idle", {7'd0, cp_en_hi}, 8'd0);
        drive_edge();
        ref_hi = 0; fb_hi = 0;
        tick();

        // R3 feedback leads
        drive_edge();
        fb_hi = 1;
        tick();
        chk("R3", "down after fb edge", ud_hi(), 8'b01);
        tick();
        drive_edge();
        ref_hi = 1;
        tick();
        chk("R3", "both after ref edge", ud_hi(), 8'b11);
        tick();
        tick();
        chk("R3", "clear after interval", ud_hi(), 8'b00);
        drive_edge();
        ref_hi = 0; fb_hi = 0;
        tick();

        // R4 simultaneous edges
        drive_edge();
        ref_hi = 1; fb_hi = 1;
        tick();
        chk("R4", "min pulse c1", ud_hi(), 8'b11);
        tick();
        chk("R4", "min pulse c2", ud_hi(), 8'b11);
        tick();
        chk("R4", "min pulse ends", ud_hi(), 8'b00);
        drive_edge();
        ref_hi = 0; fb_hi = 0;
        tick();

        // R13 edge during clear interval
        drive_edge();
        ref_hi = 1; fb_hi = 1;
        tick();
        drive_edge();
        ref_hi = 0;
        tick();
        chk("R13", "still clearing", ud_hi(), 8'b11);
        drive_edge();
        ref_hi = 1;
        tick();
        chk("R13", "edge in clear ignored", ud_hi(), 8'b00);
        tick();
        chk("R13", "no late request", ud_hi(), 8'b00);
        drive_edge();
        ref_hi = 0; fb_hi = 0;
        tick();

        // R5 polarity swap on low band
        drive_edge();
        pol_lo = 0; ref_lo = 1;
        tick();
        chk("R5", "swapped lone ref gives down", ud_lo(), 8'b01);
        chk("R5", "high band unaffected", ud_hi(), 8'b00);
        drive_edge();
        pol_lo = 1;
        #1 chk("R5", "restored polarity gives up", ud_lo(), 8'b10);
        drive_edge();
        fb_lo = 1;
        tick();
        tick();
        tick();
        chk("R5", "low band clears", ud_lo(), 8'b00);
        drive_edge();
        ref_lo = 0; fb_lo = 0;

        // R12 gain select
        drive_edge();
        gain_hi = 1; gain_lo = 0;
        #1 chk("R12", "gain pair 10", {6'd0, cp_gain_hi, cp_gain_lo}, 8'b10);
        drive_edge();
        gain_hi = 0; gain_lo = 1;
        #1 chk("R12", "gain pair 01", {6'd0, cp_gain_hi, cp_gain_lo}, 8'b01);

        // R11 powerdown over a driving code
        drive_edge();
        out_sel = 4'd2; pwr_down = 1;
        #1 chk("R11", "pin released in powerdown", {6'd0, test_out, test_oe}, 8'b00);
        drive_edge();
        pwr_down = 0;
        #1 chk("R9", "pin drives after powerdown", {6'd0, test_out, test_oe}, 8'b11);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule